// File: doc/BRIEF.md
# Bit Field Extractor with Sign Extension

This unit pulls a bit field out of a 32-bit data word. A 9-bit descriptor gives both the starting bit and the field size. The data word is shifted right logically by the start position. The shifted value is then masked down to the requested number of bits. The field can be returned zero-extended or sign-extended to the full word. Because the size code is four bits wide, the field is at most 15 bits, so the whole descriptor fits in a 9-bit immediate.

A second operation turns an unsigned comparison of the data word against the descriptor into a two-bit flag word. The caller can then store the flags as ordinary data. Every operation takes one cycle. A result register and a valid flag present each answer on the cycle after the request.

Top module: `bitfield_unit`

## Requirements
- R1: For extract operations, the data word is shifted right logically by sIn[4:0] (0 to 31 positions), and zeros enter from the top before masking.
- R2: With opSel = 0 (zero-extend extract), the result is (dIn >> sIn[4:0]) & ((1 << sIn[8:5]) - 1), and every bit at or above the field size is 0.
- R3: A size code sIn[8:5] of 0 gives a result of 0 for both opSel = 0 and opSel = 1, whatever the data.
- R4: With opSel = 1 (sign-extend extract), the low sIn[8:5] bits match R2. Every higher bit equals bit sIn[8:5]-1 of the masked field.
- R5: With opSel = 2 (compare), result[31:2] is 0. result[1] is 1 exactly when dIn equals sIn zero-extended to 32 bits. result[0] is 1 exactly when dIn is less than that value, compared unsigned.
- R6: opSel = 3 is reserved and produces a result of 0.
- R7: A request accepted with inValid high at a rising clock edge appears on result, with outValid high, after that same edge. outValid is low in every cycle that follows an edge where inValid was low.
- R8: While inValid is low, result keeps the last value produced, and opSel, dIn and sIn have no effect on it.
- R9: While rstN is low, result is 0 and outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opSel | input | 2 | 0 zero-extend extract, 1 sign-extend extract, 2 compare, 3 reserved |
| dIn | input | 32 | Data word |
| sIn | input | 9 | Descriptor: [4:0] shift, [8:5] field size; also the compare operand |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| result | output | 32 | Registered result |

## Verification
The hardest case to reach is sign extension with the field's top bit set at every shift and size. It only appears when the data bit sitting at position shift+size-1 happens to be 1. To cover it, the stimulus sweeps all 512 shift and size pairs in both extract modes. Each pair gets a random word, and is repeated with that bit forced to 1.

The compare mode needs operands that are exactly equal, which random data almost never produces. It also needs the data to fall just below or just above the 9-bit operand. These cases are therefore driven on purpose. The stimulus also places idle cycles between requests, with garbage on the inputs, to show that the result holds.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  typedef enum logic [1:0] {
    OP_ZEXT    = 2'd0,
    OP_SEXT    = 2'd1,
    OP_CMP     = 2'd2,
    OP_RSVD    = 2'd3
  } bfx_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new result this cycle
    logic doExtract;  // select the field path
    logic doSign;     // replicate the field's top bit upward
    logic doCompare;  // select the flag path
  } bfx_ctrl_t;

endpackage

// File: rtl/bfx_ctrl.sv
module bfx_ctrl
  import bfx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opSel,
  output bfx_ctrl_t  ctl,
  output logic       outValid
);

  bfx_op_e opCode;
  assign opCode = bfx_op_e'(opSel);

  always_comb begin
    ctl = '0;
    ctl.load = inValid;
    if (inValid) begin
      unique case (opCode)
        OP_ZEXT: ctl.doExtract = 1'b1;
        OP_SEXT: begin
          ctl.doExtract = 1'b1;
          ctl.doSign    = 1'b1;
        end
        OP_CMP:  ctl.doCompare = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R7: valid strobe follows the request by one cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
  import bfx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WIDTH_W = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  bfx_ctrl_t                            ctl,
  input  logic [DATA_W-1:0]                    dIn,
  input  logic [$clog2(DATA_W)+WIDTH_W-1:0]    sIn,
  output logic [DATA_W-1:0]                    result
);

  localparam int SHIFT_W = $clog2(DATA_W);
  localparam int S_W     = SHIFT_W + WIDTH_W;
  localparam int MAX_FW  = 1 << WIDTH_W;

  logic [SHIFT_W-1:0] shiftAmt;
  logic [WIDTH_W-1:0] fieldWidth;
  logic [DATA_W-1:0]  shifted;
  logic [DATA_W-1:0]  maskBits;
  logic [DATA_W-1:0]  topMark;
  logic               signBit;
  logic [DATA_W-1:0]  fillBits;
  logic [DATA_W-1:0]  extracted;
  logic [DATA_W-1:0]  sWide;
  logic [DATA_W-1:0]  flagWord;
  logic [DATA_W-1:0]  nextResult;

  assign shiftAmt   = sIn[SHIFT_W-1:0];
  assign fieldWidth = sIn[S_W-1:SHIFT_W];
  assign shifted    = dIn >> shiftAmt;

  // Thermometer mask: bit i set when i lies below the field size
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < MAX_FW) begin : g_live
      assign maskBits[i] = (fieldWidth > WIDTH_W'(i));
    end else begin : g_dead
      assign maskBits[i] = 1'b0;
    end
  end

  // One-hot marker on the field's top bit (empty when size is zero)
  assign topMark = maskBits ^ (maskBits >> 1);
  assign signBit = |(shifted & topMark);

  for (genvar i = 0; i < DATA_W; i++) begin : g_fill
    assign fillBits[i] = ctl.doSign & signBit & ~maskBits[i];
  end

  assign extracted = (shifted & maskBits) | fillBits;

  assign sWide    = {{(DATA_W-S_W){1'b0}}, sIn};
  assign flagWord = {{(DATA_W-2){1'b0}}, (dIn == sWide), (dIn < sWide)};

  always_comb begin
    if (ctl.doCompare)      nextResult = flagWord;
    else if (ctl.doExtract) nextResult = extracted;
    else                    nextResult = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         result <= '0;
    else if (ctl.load) result <= nextResult;
  end

  // R3: empty field yields zero in both extract modes
  a_r3_empty_field: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.doExtract && fieldWidth == '0) |=> (result == '0));

  // R5: compare leaves the upper bits clear
  a_r5_flag_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.doCompare) |=> (result[DATA_W-1:2] == '0));

  // R5: equality and less-than never both set
  a_r5_flag_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.doCompare) |=> !(result[1] && result[0]));

  // R6: reserved operation returns zero
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.doExtract && !ctl.doCompare) |=> (result == '0));

  // R2: zero-extend never sets bits at or above the size
  a_r2_zext_upper: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.doExtract && !ctl.doSign) |=> (result[DATA_W-1:MAX_FW] == '0));

  // R8: idle cycles keep the result
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(result));

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WIDTH_W = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  input  logic [1:0]                        opSel,
  input  logic [DATA_W-1:0]                 dIn,
  input  logic [$clog2(DATA_W)+WIDTH_W-1:0] sIn,
  output logic                              outValid,
  output logic [DATA_W-1:0]                 result
);

  bfx_ctrl_t ctl;

  bfx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .ctl      (ctl),
    .outValid (outValid)
  );

  bfx_datapath #(
    .DATA_W  (DATA_W),
    .WIDTH_W (WIDTH_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .dIn    (dIn),
    .sIn    (sIn),
    .result (result)
  );

endmodule

// File: tb/sim_bitfield_unit.sv
module sim_bitfield_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = '0;
  logic [31:0] dIn = '0;
  logic [8:0]  sIn = '0;
  logic        outValid;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t expQ[$];
  logic [31:0] lastExp = '0;

  always #5 clk = ~clk;

  bitfield_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .dIn(dIn), .sIn(sIn), .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] refModel(input logic [1:0] op,
                                           input logic [31:0] d,
                                           input logic [8:0] s);
    logic [31:0] fld;
    logic [31:0] msk;
    int sh;
    int w;
    sh = int'(s[4:0]);
    w  = int'(s[8:5]);
    msk = (32'h1 << w) - 32'h1;
    fld = (d >> sh) & msk;
    case (op)
      2'd0: return fld;
      2'd1: begin
        if (w > 0 && fld[w-1]) return fld | ~msk;
        return fld;
      end
      2'd2: return {30'd0, d == {23'd0, s}, d < {23'd0, s}};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendOp(input logic [1:0] op, input logic [31:0] d,
                        input logic [8:0] s, input string req);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1;
    opSel = op;
    dIn = d;
    sIn = s;
    e.val = refModel(op, d, s);
    e.req = req;
    expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    opSel = 2'($urandom);
    dIn = $urandom;
    sIn = 9'($urandom);
  endtask

  // Monitor: samples 2 ns after each rising edge
  initial begin
    bit first = 1;
    wait (rstN);
    forever begin
      @(posedge clk);
      #2;
      if (finished) break;
      if (first) begin
        check("R9 reset outValid", {31'd0, outValid}, 32'd0);
        check("R9 reset result", result, 32'd0);
        first = 0;
      end else if (expQ.size() != 0) begin
        exp_t e;
        e = expQ.pop_front();
        check("R7 outValid high", {31'd0, outValid}, 32'd1);
        check(e.req, result, e.val);
        lastExp = e.val;
      end else begin
        check("R7 outValid low", {31'd0, outValid}, 32'd0);
        check("R8 hold", result, lastExp);
      end
    end
  end

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog R7 actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: result and valid are checked held low during reset
    repeat (2) @(posedge clk);
    #2;
    check("R9 in reset outValid", {31'd0, outValid}, 32'd0);
    check("R9 in reset result", result, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    idle();

    // R1 R2 R4: full sweep, random data, plus forced top bit
    for (int sh = 0; sh < 32; sh++) begin
      for (int w = 0; w < 16; w++) begin
        logic [31:0] d;
        d = $urandom;
        sendOp(2'd0, d, {4'(w), 5'(sh)}, (w == 0) ? "R3 zext" : "R2 R1 zext");
        sendOp(2'd1, d, {4'(w), 5'(sh)}, (w == 0) ? "R3 sext" : "R4 R1 sext");
        if (w > 0 && sh + w - 1 < 32) d[sh + w - 1] = 1'b1;
        sendOp(2'd1, d, {4'(w), 5'(sh)}, "R4 sext top set");
      end
      idle();
    end

    // R1: all ones with largest shift must bring zeros in
    sendOp(2'd0, 32'hFFFF_FFFF, {4'd15, 5'd31}, "R1 top fill zero");
    sendOp(2'd1, 32'h8000_0000, {4'd1, 5'd31}, "R4 single bit sign");
    // R3: empty field on all-ones data
    sendOp(2'd0, 32'hFFFF_FFFF, {4'd0, 5'd7}, "R3 zext empty");
    sendOp(2'd1, 32'hFFFF_FFFF, {4'd0, 5'd0}, "R3 sext empty");

    // R5: compare corners
    sendOp(2'd2, 32'd100, 9'd100, "R5 equal");
    sendOp(2'd2, 32'd99, 9'd100, "R5 less");
    sendOp(2'd2, 32'd101, 9'd100, "R5 greater");
    sendOp(2'd2, 32'd0, 9'd0, "R5 zero equal");
    sendOp(2'd2, 32'd511, 9'd511, "R5 max equal");
    sendOp(2'd2, 32'hFFFF_FFFF, 9'd511, "R5 unsigned big");
    sendOp(2'd2, 32'd0, 9'd1, "R5 zero less");
    for (int k = 0; k < 40; k++) begin
      logic [31:0] d;
      d = (k % 2 == 0) ? ($urandom % 600) : $urandom;
      sendOp(2'd2, d, 9'($urandom), "R5 random");
    end

    // R6: reserved op
    sendOp(2'd3, 32'hDEAD_BEEF, 9'h1FF, "R6 reserved");
    sendOp(2'd0, 32'h0000_F000, {4'd4, 5'd12}, "R2 after reserved");
    // R8: idle cycles with garbage inputs keep the result
    idle();
    idle();
    idle();
    sendOp(2'd3, 32'h1234_5678, 9'd3, "R6 reserved again");
    idle();
    idle();

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    if (expQ.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R7 pending actual=%0d expected=0", expQ.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule